// File: doc/BRIEF.md
# Bank-Aware Prefetch Issue Scheduler

This block sits between a hardware prefetcher and the miss-handling registers of one core. Incoming prefetches arrive with an address and an already decoded DRAM bank index and are queued in a small FIFO dedicated to that bank. Each cycle the scheduler looks only at the oldest entry of every bank queue. It offers one of them on a single valid/ready output toward the miss registers: the one whose bank currently has the fewest outstanding miss-register entries.

The scheduler keeps one counter per bank. A miss-register allocation for that bank raises it and a release lowers it. A bank head may be issued only while its counter does not exceed a send threshold. The threshold follows the measured usefulness of prefetches. Over fixed intervals the block counts prefetches reported as issued and those reported as used. At each interval boundary it classifies the ratio into one of three accuracy bands, and each band selects one of three programmable thresholds. Low accuracy therefore reserves miss registers for demand traffic, and high accuracy spreads prefetches across banks.

Top module: `pf_bank_sched`

## Requirements
- R1: After reset every bank queue is empty, every occupancy counter is zero, `out_valid` is 0, `in_ready` is 1, and the send threshold is `thr_high` until the first accuracy update.
- R2: Entries of one bank leave in the order they were accepted, and `out_valid` is never 1 for a bank whose queue is empty.
- R3: `in_ready` is 0 exactly when the queue of the bank on `in_bank` holds `FIFO_DEPTH` entries. A prefetch offered while `in_ready` is 0 is not stored.
- R4: A bank's occupancy counter rises by one on `alloc_valid` for that bank and falls by one on `dealloc_valid` for that bank. It does not move when both fall on the same bank in the same cycle, and it saturates at 0 and at its maximum.
- R5: A bank head is eligible only when the bank's occupancy counter is less than or equal to the current send threshold.
- R6: Among eligible heads, the output carries the one whose bank has the smallest occupancy. Ties go to the lowest bank index, and `out_bank` names that bank.
- R7: At most one entry leaves per cycle, and only on a cycle with `out_valid` and `out_ready` both 1. While `out_ready` is 0 the offered entry stays put.
- R8: On every clock edge numbered a multiple of `INTERVAL` after reset release, the band is recomputed from the interval's counts U (used) and I (issued). It is high when 20·U > 17·I, that is above 85%. It is low when 5·U < 2·I, that is below 40%. Otherwise it is mid, with exactly 85% and exactly 40% both mid. The band selects `thr_high`, `thr_low` or `thr_mid` as the send threshold.
- R9: Both counts restart from zero after every boundary, so one interval's strobes never affect the next decision.
- R10: An interval with no issued strobe leaves the band unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Prefetch offered by the prefetcher |
| in_ready | output | 1 | Queue of `in_bank` can accept |
| in_addr | input | ADDR_W | Prefetch address |
| in_bank | input | BANK_W | Decoded bank of the prefetch |
| alloc_valid | input | 1 | A miss register was allocated |
| alloc_bank | input | BANK_W | Bank of that allocation |
| dealloc_valid | input | 1 | A miss register was released |
| dealloc_bank | input | BANK_W | Bank of that release |
| pf_used | input | 1 | A prefetched line was referenced |
| pf_issued | input | 1 | A prefetch was sent to memory |
| thr_low | input | OCC_W | Threshold for the low band |
| thr_mid | input | OCC_W | Threshold for the mid band |
| thr_high | input | OCC_W | Threshold for the high band |
| out_valid | output | 1 | A prefetch is offered to the miss registers |
| out_ready | input | 1 | Miss registers take the offered prefetch |
| out_addr | output | ADDR_W | Address of the offered prefetch |
| out_bank | output | BANK_W | Bank of the offered prefetch |

## Verification
Two pairs of functions can land in the same cycle. An allocation and a release can hit one bank together, and a push and a pop can hit one bank queue together. The bench sets two banks to equal occupancy and then pulses allocation and release on each of them. Whichever event wrongly wins would change which bank is picked. It also pushes into a bank queue on the cycle that bank's head leaves, then drains the queue and compares the addresses in order. The choice of bank is judged across every combination of occupancies 0 to 3 on four banks, against a minimum-with-threshold model computed in the bench.

// File: rtl/pf_sched_pkg.sv
package pf_sched_pkg;

  // Accuracy classes produced at each interval boundary.
  typedef enum logic [1:0] {
    ACC_LOW  = 2'd0,
    ACC_MID  = 2'd1,
    ACC_HIGH = 2'd2
  } acc_band_e;

endpackage

// File: rtl/pf_bank_fifo.sv
module pf_bank_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             full,
  output logic [LVL_W-1:0] level
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             do_push, do_pop;

  always_comb begin
    full    = (lvl_q == LVL_W'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && (lvl_q != '0);
    wr_d    = wr_q;
    rd_d    = rd_q;
    lvl_d   = lvl_q;
    if (do_push) wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + PTR_W'(1);
    if (do_pop)  rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + PTR_W'(1);
    if (do_push && !do_pop)      lvl_d = lvl_q + LVL_W'(1);
    else if (do_pop && !do_push) lvl_d = lvl_q - LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  // Storage carries no reset; the level guards every read.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign level = lvl_q;

endmodule

// File: rtl/pf_occ_counter.sv
module pf_occ_counter #(
  parameter int OCC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [OCC_W-1:0] count
);

  logic [OCC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec && (cnt_q != '1))      cnt_d = cnt_q + OCC_W'(1);
    else if (dec && !inc && (cnt_q != '0)) cnt_d = cnt_q - OCC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/pf_accuracy.sv
module pf_accuracy
  import pf_sched_pkg::*;
#(
  parameter int INTERVAL = 100000,
  parameter int OCC_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pf_used,
  input  logic             pf_issued,
  input  logic [OCC_W-1:0] thr_low,
  input  logic [OCC_W-1:0] thr_mid,
  input  logic [OCC_W-1:0] thr_high,
  output logic [OCC_W-1:0] send_thr
);

  localparam int TICK_W = $clog2(INTERVAL);
  localparam int EV_W   = $clog2(INTERVAL + 1);
  localparam int PROD_W = EV_W + 5;

  logic [TICK_W-1:0] tick_q, tick_d;
  logic [EV_W-1:0]   used_q, used_d, iss_q, iss_d;
  logic [EV_W-1:0]   used_tot, iss_tot;
  logic [PROD_W-1:0] used_x20, used_x5, iss_x17, iss_x2;
  logic              last;
  acc_band_e         band_q, band_d;

  always_comb begin
    last     = (tick_q == TICK_W'(INTERVAL - 1));
    // Strobes on the boundary cycle still belong to the closing interval.
    used_tot = used_q + EV_W'(pf_used);
    iss_tot  = iss_q + EV_W'(pf_issued);
    used_x20 = PROD_W'(used_tot) * PROD_W'(20);
    used_x5  = PROD_W'(used_tot) * PROD_W'(5);
    iss_x17  = PROD_W'(iss_tot) * PROD_W'(17);
    iss_x2   = PROD_W'(iss_tot) * PROD_W'(2);
    tick_d   = last ? '0 : tick_q + TICK_W'(1);
    used_d   = last ? '0 : used_tot;
    iss_d    = last ? '0 : iss_tot;
    band_d   = band_q;
    if (last && (iss_tot != '0)) begin
      if (used_x20 > iss_x17)    band_d = ACC_HIGH;
      else if (used_x5 < iss_x2) band_d = ACC_LOW;
      else                       band_d = ACC_MID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      used_q <= '0;
      iss_q  <= '0;
      band_q <= ACC_HIGH;
    end else begin
      tick_q <= tick_d;
      used_q <= used_d;
      iss_q  <= iss_d;
      band_q <= band_d;
    end
  end

  always_comb begin
    case (band_q)
      ACC_LOW:  send_thr = thr_low;
      ACC_MID:  send_thr = thr_mid;
      default:  send_thr = thr_high;
    endcase
  end

endmodule

// File: rtl/pf_pick.sv
module pf_pick #(
  parameter int NUM_BANKS = 4,
  parameter int OCC_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS-1:0]            cand,
  input  logic [NUM_BANKS-1:0][OCC_W-1:0] occ,
  input  logic [OCC_W-1:0]                thr,
  output logic                            any,
  output logic [BANK_W-1:0]               sel
);

  logic [OCC_W-1:0] best;

  // Strict less-than keeps the lowest index among equal occupancies.
  always_comb begin
    any  = 1'b0;
    sel  = '0;
    best = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (cand[b] && (occ[b] <= thr) && (!any || (occ[b] < best))) begin
        any  = 1'b1;
        sel  = BANK_W'(b);
        best = occ[b];
      end
    end
  end

endmodule

// File: rtl/pf_bank_sched.sv
module pf_bank_sched #(
  parameter int NUM_BANKS  = 4,
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int OCC_W      = 6,
  parameter int INTERVAL   = 100000,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BANK_W-1:0] in_bank,
  input  logic              alloc_valid,
  input  logic [BANK_W-1:0] alloc_bank,
  input  logic              dealloc_valid,
  input  logic [BANK_W-1:0] dealloc_bank,
  input  logic              pf_used,
  input  logic              pf_issued,
  input  logic [OCC_W-1:0]  thr_low,
  input  logic [OCC_W-1:0]  thr_mid,
  input  logic [OCC_W-1:0]  thr_high,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BANK_W-1:0] out_bank
);

  logic [NUM_BANKS-1:0]             full;
  logic [NUM_BANKS-1:0]             nonempty;
  logic [NUM_BANKS-1:0][LVL_W-1:0]  lvl;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] heads;
  logic [NUM_BANKS-1:0][OCC_W-1:0]  occ;
  logic [OCC_W-1:0]                 send_thr;
  logic [BANK_W-1:0]                sel;
  logic                             any;
  logic                             take;

  assign in_ready = !full[in_bank];
  assign take     = any && out_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_push, bank_pop, bank_inc, bank_dec;

    assign bank_push   = in_valid && in_ready && (in_bank == BANK_W'(b));
    assign bank_pop    = take && (sel == BANK_W'(b));
    assign bank_inc    = alloc_valid && (alloc_bank == BANK_W'(b));
    assign bank_dec    = dealloc_valid && (dealloc_bank == BANK_W'(b));
    assign nonempty[b] = (lvl[b] != '0);

    pf_bank_fifo #(
      .W     (ADDR_W),
      .DEPTH (FIFO_DEPTH)
    ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (bank_push),
      .din   (in_addr),
      .pop   (bank_pop),
      .dout  (heads[b]),
      .full  (full[b]),
      .level (lvl[b])
    );

    pf_occ_counter #(
      .OCC_W (OCC_W)
    ) u_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (bank_inc),
      .dec   (bank_dec),
      .count (occ[b])
    );
  end

  pf_accuracy #(
    .INTERVAL (INTERVAL),
    .OCC_W    (OCC_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .pf_used   (pf_used),
    .pf_issued (pf_issued),
    .thr_low   (thr_low),
    .thr_mid   (thr_mid),
    .thr_high  (thr_high),
    .send_thr  (send_thr)
  );

  pf_pick #(
    .NUM_BANKS (NUM_BANKS),
    .OCC_W     (OCC_W)
  ) u_pick (
    .cand (nonempty),
    .occ  (occ),
    .thr  (send_thr),
    .any  (any),
    .sel  (sel)
  );

  assign out_valid = any;
  assign out_bank  = sel;
  assign out_addr  = heads[sel];

endmodule

// File: rtl/pf_bank_sched_chk.sv
module pf_bank_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int OCC_W     = 6,
  parameter int LVL_W     = 3,
  parameter int BANK_W    = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            in_valid,
  input logic                            in_ready,
  input logic [BANK_W-1:0]               in_bank,
  input logic                            alloc_valid,
  input logic [BANK_W-1:0]               alloc_bank,
  input logic                            dealloc_valid,
  input logic [BANK_W-1:0]               dealloc_bank,
  input logic                            out_valid,
  input logic [BANK_W-1:0]               out_bank,
  input logic [NUM_BANKS-1:0][OCC_W-1:0] occ,
  input logic [NUM_BANKS-1:0][LVL_W-1:0] lvl,
  input logic [OCC_W-1:0]                send_thr
);

  logic better_exists;

  always_comb begin
    better_exists = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if ((lvl[b] != '0) && (occ[b] <= send_thr) &&
          ((occ[b] < occ[out_bank]) ||
           ((occ[b] == occ[out_bank]) && (BANK_W'(b) < out_bank))))
        better_exists = 1'b1;
    end
  end

  assert_head_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lvl[out_bank] != '0));

  assert_under_threshold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (occ[out_bank] <= send_thr));

  assert_least_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !better_exists);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready && (in_bank == BANK_W'(b))) |=> (lvl[b] <= $past(lvl[b])));

    assert_occ_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && dealloc_valid && (alloc_bank == BANK_W'(b)) &&
       (dealloc_bank == BANK_W'(b))) |=> $stable(occ[b]));
  end

endmodule

bind pf_bank_sched pf_bank_sched_chk #(
  .NUM_BANKS (NUM_BANKS),
  .OCC_W     (OCC_W),
  .LVL_W     (LVL_W),
  .BANK_W    (BANK_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_bank       (in_bank),
  .alloc_valid   (alloc_valid),
  .alloc_bank    (alloc_bank),
  .dealloc_valid (dealloc_valid),
  .dealloc_bank  (dealloc_bank),
  .out_valid     (out_valid),
  .out_bank      (out_bank),
  .occ           (occ),
  .lvl           (lvl),
  .send_thr      (send_thr)
);

// File: tb/pf_bank_sched_tb.sv
module pf_bank_sched_tb;

  localparam int NB    = 4;
  localparam int AW    = 16;
  localparam int DEPTH = 4;
  localparam int OW    = 4;
  localparam int INTV  = 32;
  localparam int BW    = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready;
  logic [AW-1:0] in_addr;
  logic [BW-1:0] in_bank;
  logic          alloc_valid, dealloc_valid;
  logic [BW-1:0] alloc_bank, dealloc_bank;
  logic          pf_used, pf_issued;
  logic [OW-1:0] thr_low, thr_mid, thr_high;
  logic          out_valid, out_ready;
  logic [AW-1:0] out_addr;
  logic [BW-1:0] out_bank;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int occ_m [NB];

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  pf_bank_sched #(
    .NUM_BANKS  (NB),
    .ADDR_W     (AW),
    .FIFO_DEPTH (DEPTH),
    .OCC_W      (OW),
    .INTERVAL   (INTV)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_addr       (in_addr),
    .in_bank       (in_bank),
    .alloc_valid   (alloc_valid),
    .alloc_bank    (alloc_bank),
    .dealloc_valid (dealloc_valid),
    .dealloc_bank  (dealloc_bank),
    .pf_used       (pf_used),
    .pf_issued     (pf_issued),
    .thr_low       (thr_low),
    .thr_mid       (thr_mid),
    .thr_high      (thr_high),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_addr      (out_addr),
    .out_bank      (out_bank)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int bank, input int addr);
    in_valid = 1'b1;
    in_bank  = BW'(bank);
    in_addr  = AW'(addr);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Takes the offered entry, checking bank and address first.
  task automatic pop_expect(input string req, input int bank, input int addr);
    check(out_valid == 1'b1, req, "pop valid", out_valid, 1);
    check(out_bank == BW'(bank), req, "pop bank", out_bank, bank);
    check(out_addr == AW'(addr), req, "pop addr", out_addr, addr);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic set_occ(input int tgt [NB]);
    for (int b = 0; b < NB; b++) begin
      while (occ_m[b] < tgt[b]) begin
        alloc_valid = 1'b1; alloc_bank = BW'(b);
        @(negedge clk);
        occ_m[b]++;
      end
      alloc_valid = 1'b0;
      while (occ_m[b] > tgt[b]) begin
        dealloc_valid = 1'b1; dealloc_bank = BW'(b);
        @(negedge clk);
        occ_m[b]--;
      end
      dealloc_valid = 1'b0;
    end
  endtask

  task automatic align_interval();
    @(negedge clk);
    while ((cyc % INTV) != 0) @(negedge clk);
  endtask

  // One full interval with n issued strobes of which u also report use.
  task automatic run_interval(input int n, input int u);
    align_interval();
    for (int i = 0; i < n; i++) begin
      pf_issued = 1'b1;
      pf_used   = (i < u);
      @(negedge clk);
    end
    pf_issued = 1'b0;
    pf_used   = 1'b0;
    align_interval();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t [NB];
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_bank = '0;
    alloc_valid = 1'b0; alloc_bank = '0; dealloc_valid = 1'b0; dealloc_bank = '0;
    pf_used = 1'b0; pf_issued = 1'b0; out_ready = 1'b0;
    thr_low = OW'(0); thr_mid = OW'(1); thr_high = OW'(2);
    for (int b = 0; b < NB; b++) occ_m[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R2 order and R7 hold while not ready
    push(1, 'h1100); push(1, 'h1101); push(1, 'h1102);
    for (int i = 0; i < 3; i++) begin
      check(out_valid && out_addr == AW'('h1100), "R7", "held head addr", out_addr, 'h1100);
      @(negedge clk);
    end
    pop_expect("R2", 1, 'h1100);
    pop_expect("R2", 1, 'h1101);
    pop_expect("R7", 1, 'h1102);
    check(out_valid == 1'b0, "R2", "valid after drain", out_valid, 0);

    // R3 backpressure on a full bank, nothing stored when refused
    for (int i = 0; i < DEPTH; i++) push(2, 'h2200 + i);
    in_bank = BW'(2);
    #1 check(in_ready == 1'b0, "R3", "ready on full bank", in_ready, 0);
    in_bank = BW'(0);
    #1 check(in_ready == 1'b1, "R3", "ready on other bank", in_ready, 1);
    push(2, 'hDEAD); push(2, 'hDEAD);
    for (int i = 0; i < DEPTH; i++) pop_expect("R3", 2, 'h2200 + i);
    check(out_valid == 1'b0, "R3", "refused entry absent", out_valid, 0);

    // R2 push and pop on the same bank in one cycle
    push(3, 'h3300); push(3, 'h3301);
    in_valid = 1'b1; in_bank = BW'(3); in_addr = AW'('h3302);
    pop_expect("R2", 3, 'h3300);
    in_valid = 1'b0;
    pop_expect("R2", 3, 'h3301);
    pop_expect("R2", 3, 'h3302);
    check(out_valid == 1'b0, "R2", "valid after concurrent drain", out_valid, 0);

    // R4 R5 R6: sweep every occupancy 0..3 on four banks, threshold 2
    for (int b = 0; b < NB; b++) push(b, 'h4000 + b);
    for (int c = 0; c < 256; c++) begin
      int best;
      int bocc;
      for (int b = 0; b < NB; b++) t[b] = (c >> (2 * b)) & 3;
      set_occ(t);
      best = -1; bocc = 0;
      for (int b = 0; b < NB; b++)
        if (t[b] <= 2 && (best < 0 || t[b] < bocc)) begin best = b; bocc = t[b]; end
      if (best < 0)
        check(out_valid == 1'b0, "R5", "no eligible bank", out_valid, 0);
      else
        check(out_valid && out_bank == BW'(best) && out_addr == AW'('h4000 + best),
              "R6", "least busy bank", {out_valid, out_bank}, {1'b1, BW'(best)});
    end

    // R4: alloc and release on one bank in the same cycle cancel
    t = '{1, 1, 3, 3};
    set_occ(t);
    alloc_valid = 1'b1; alloc_bank = BW'(0); dealloc_valid = 1'b1; dealloc_bank = BW'(0);
    @(negedge clk);
    alloc_bank = BW'(1); dealloc_bank = BW'(1);
    @(negedge clk);
    alloc_valid = 1'b0; dealloc_valid = 1'b0;
    check(out_valid && out_bank == BW'(0), "R4", "bank after cancelling events", out_bank, 0);

    // R8: accuracy bands select thresholds (low 0, mid 1, high 2)
    run_interval(10, 1);
    check(out_valid == 1'b0, "R8", "10% gives low threshold", out_valid, 0);
    run_interval(10, 5);
    check(out_valid == 1'b1, "R8", "50% gives mid threshold", out_valid, 1);
    t = '{2, 3, 3, 3};
    set_occ(t);
    check(out_valid == 1'b0, "R8", "occ 2 above mid threshold", out_valid, 0);
    run_interval(10, 9);
    check(out_valid == 1'b1, "R8", "90% gives high threshold", out_valid, 1);
    run_interval(20, 17);
    check(out_valid == 1'b0, "R8", "exactly 85% is mid", out_valid, 0);
    t = '{1, 3, 3, 3};
    set_occ(t);
    run_interval(10, 4);
    check(out_valid == 1'b1, "R8", "exactly 40% is mid", out_valid, 1);

    // R10: no issued strobe keeps the band (mid)
    run_interval(0, 0);
    check(out_valid == 1'b1, "R10", "empty interval keeps band", out_valid, 1);

    // R9: counts restart each interval
    run_interval(10, 9);
    run_interval(10, 0);
    check(out_valid == 1'b0, "R9", "0% after 90% interval is low", out_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule